// File: doc/BRIEF.md
# Isolated I/O Port Decoder

This block sits on the peripheral side of a processor bus that keeps I/O ports in their own address space, apart from memory. Each bus cycle presents a 16-bit port address, a flag that marks the cycle as I/O rather than memory, read and write strobes, two byte-lane enables for the 16-bit data bus, and a flag for a 32-bit group transfer. The strobe inputs are active high. Lane 0 is the low byte (data bits 7:0) and lane 1 is the high byte (data bits 15:8).

The block produces four kinds of output:
- Eight active-low chip selects for a block of consecutive 8-bit ports at EFF8h to EFFFh.
- One active-low select for a 32-bit port group at 0070h.
- A pair of 8-bit output latches at ports 0040h and 0041h, one in each byte bank, each with its own write strobe.
- A 16-bit input port at 0064h/0065h. Its three-state drive is modelled as a data bus plus an output enable.

Every select and the input-port enable are combinational functions of the current address and control lines. The latches are registers that load on the clock edge at which their write strobe is active.

Top module: `io_port_decoder`

## Requirements
- R1: When `io_cycle` is 0 (a memory cycle), every select stays high, `rdata_oe` stays 0 and neither latch changes, whatever the address, strobes and lanes.
- R2: All 16 address bits are compared. An 8-bit port number appears as 00h in bits 15:8 and the port in bits 7:0. Addresses that differ from a decoded port only above bit 7 (such as 1040h or 0164h) decode to nothing.
- R3: In an I/O cycle with `rd_stb` or `wr_stb` high and address bits 15:3 equal to EFF8h>>3, `blk_sel_n` bit k (k = address bits 2:0) is 0 and all other bits are 1. Otherwise `blk_sel_n` is FFh.
- R4: The latches share the word address 0040h/0041h (bits 15:1 compared). On an I/O write to that word, `lane_en[0]` loads `out_q[7:0]` from `wdata[7:0]` and `lane_en[1]` loads `out_q[15:8]` from `wdata[15:8]`. The new value appears after that clock edge.
- R5: A 16-bit write (both lanes) to 0040h loads both latches on the same edge. An 8-bit write to 0041h with only `lane_en[1]` loads only the high latch.
- R6: Each latch holds its value through reads, idle cycles and writes to any other address, until the next write that targets it.
- R7: An I/O read (`rd_stb`=1) with address bits 15:1 equal to 0064h>>1 sets `rdata_oe` to 1 and drives `in_data` onto `rdata`, for any value of `lane_en`.
- R8: In every other cycle, including writes to 0064h, `rdata_oe` is 0 and `rdata` is 0000h.
- R9: `grp_sel_n` goes low only in an I/O read or write cycle with `wide32`=1 and an address of exactly 0070h. A misaligned group address (0071h to 0073h) or `wide32`=0 is not decoded.
- R10: While `rst` is high at a clock edge, both latches become 00h. Reset takes priority over a write in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| io_cycle | input | 1 | 1 = I/O cycle, 0 = memory cycle |
| rd_stb | input | 1 | Read strobe, active high |
| wr_stb | input | 1 | Write strobe, active high |
| wide32 | input | 1 | Cycle is a 32-bit group transfer |
| lane_en | input | 2 | Byte-lane enables, bit 0 low byte, bit 1 high byte |
| addr | input | 16 | Port address |
| wdata | input | 16 | Write data |
| in_data | input | 16 | External value of the input port |
| blk_sel_n | output | 8 | Active-low selects for ports EFF8h..EFFFh |
| grp_sel_n | output | 1 | Active-low select for the 32-bit group at 0070h |
| out_q | output | 16 | Latch contents: 7:0 = port 0040h, 15:8 = port 0041h |
| rdata | output | 16 | Read data from the input port, 0 when not driven |
| rdata_oe | output | 1 | Output enable of the input-port drivers |

## Verification
A wrong lane strobe or a broken hold path leaves the wrong byte in `out_q`. That shows one cycle after the offending write, and it stays visible until that byte is written again. The bench therefore compares both latch bytes after every cycle, not only after writes.

A select or enable decode error shows at once, in the same cycle, on `blk_sel_n`, `grp_sel_n` or `rdata_oe`. Address aliases with upper-byte bits set, memory cycles, and misaligned group addresses are mixed into the stimulus so that partial decoding shows up.

// File: rtl/iodec_pkg.sv
package iodec_pkg;
  localparam int BYTE_W = 8;

  typedef struct packed {
    logic acc;
    logic rd;
    logic wr;
  } io_qual_t;

  function automatic io_qual_t qualify(input logic io, input logic rd, input logic wr);
    io_qual_t q;
    q.acc = io & (rd | wr);
    q.rd  = io & rd;
    q.wr  = io & wr;
    return q;
  endfunction
endpackage

// File: rtl/port_block_decoder.sv
module port_block_decoder #(
  parameter int              AW    = 16,
  parameter int              PORTS = 8,
  parameter logic [AW-1:0]   BASE  = 16'hEFF8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             acc,
  input  logic [AW-1:0]    addr,
  output logic [PORTS-1:0] sel_n
);
  localparam int LSB = $clog2(PORTS);

  logic blk_hit;
  assign blk_hit = acc && (addr[AW-1:LSB] == BASE[AW-1:LSB]);

  for (genvar k = 0; k < PORTS; k++) begin : g_sel
    assign sel_n[k] = !(blk_hit && (addr[LSB-1:0] == LSB'(k)));
  end

  // R3: at most one port of the block is selected at a time
  assert_one_select_R3: assert property (@(posedge clk) disable iff (rst)
    $onehot0(~sel_n));
  // R3: any select implies an I/O access in progress
  assert_sel_needs_access_R3: assert property (@(posedge clk) disable iff (rst)
    (sel_n != '1) |-> acc);
endmodule

// File: rtl/lane_latch_bank.sv
module lane_latch_bank #(
  parameter int            AW   = 16,
  parameter int            DW   = 16,
  parameter logic [AW-1:0] BASE = 16'h0040
) (
  input  logic                          clk,
  input  logic                          rst,
  input  logic                          wr,
  input  logic [AW-1:$clog2(DW/8)]      word_addr,
  input  logic [DW/8-1:0]               lane_en,
  input  logic [DW-1:0]                 wdata,
  output logic [DW-1:0]                 q
);
  localparam int LANES = DW / iodec_pkg::BYTE_W;
  localparam int LSB   = $clog2(LANES);
  localparam int BW    = iodec_pkg::BYTE_W;

  logic             word_hit;
  logic [LANES-1:0] lane_wr;

  assign word_hit = wr && (word_addr == BASE[AW-1:LSB]);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    assign lane_wr[i] = word_hit && lane_en[i];

    always_ff @(posedge clk) begin
      if (rst)             q[i*BW +: BW] <= '0;
      else if (lane_wr[i]) q[i*BW +: BW] <= wdata[i*BW +: BW];
    end

    // R4: a strobed lane captures its own byte of the bus
    assert_lane_load_R4: assert property (@(posedge clk) disable iff (rst)
      lane_wr[i] |=> (q[i*BW +: BW] == $past(wdata[i*BW +: BW])));
    // R6: a lane without its strobe keeps its byte
    assert_lane_hold_R6: assert property (@(posedge clk) disable iff (rst)
      !lane_wr[i] |=> $stable(q[i*BW +: BW]));
  end
endmodule

// File: rtl/in_port_gate.sv
module in_port_gate #(
  parameter int            AW   = 16,
  parameter int            DW   = 16,
  parameter logic [AW-1:0] BASE = 16'h0064
) (
  input  logic                     rd,
  input  logic [AW-1:$clog2(DW/8)] word_addr,
  input  logic [DW-1:0]            in_data,
  output logic [DW-1:0]            rdata,
  output logic                     oe
);
  localparam int LSB = $clog2(DW / iodec_pkg::BYTE_W);

  assign oe    = rd && (word_addr == BASE[AW-1:LSB]);
  assign rdata = oe ? in_data : '0;
endmodule

// File: rtl/group_decoder.sv
module group_decoder #(
  parameter int            AW   = 16,
  parameter int            SPAN = 4,
  parameter logic [AW-1:0] BASE = 16'h0070
) (
  input  logic          acc,
  input  logic          wide,
  input  logic [AW-1:0] addr,
  output logic          sel_n
);
  localparam int ALSB = $clog2(SPAN);

  logic aligned, in_group;
  assign aligned  = (addr[ALSB-1:0] == '0);
  assign in_group = (addr[AW-1:ALSB] == BASE[AW-1:ALSB]);
  assign sel_n    = !(acc && wide && in_group && aligned);
endmodule

// File: rtl/io_port_decoder.sv
module io_port_decoder #(
  parameter int            AW        = 16,
  parameter int            DW        = 16,
  parameter int            BLK_PORTS = 8,
  parameter int            GRP_SPAN  = 4,
  parameter logic [AW-1:0] BLK_BASE  = 16'hEFF8,
  parameter logic [AW-1:0] OUT_BASE  = 16'h0040,
  parameter logic [AW-1:0] IN_BASE   = 16'h0064,
  parameter logic [AW-1:0] GRP_BASE  = 16'h0070
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 io_cycle,
  input  logic                 rd_stb,
  input  logic                 wr_stb,
  input  logic                 wide32,
  input  logic [DW/8-1:0]      lane_en,
  input  logic [AW-1:0]        addr,
  input  logic [DW-1:0]        wdata,
  input  logic [DW-1:0]        in_data,
  output logic [BLK_PORTS-1:0] blk_sel_n,
  output logic                 grp_sel_n,
  output logic [DW-1:0]        out_q,
  output logic [DW-1:0]        rdata,
  output logic                 rdata_oe
);
  import iodec_pkg::*;

  localparam int WLSB = $clog2(DW / BYTE_W);

  io_qual_t qual;
  assign qual = qualify(io_cycle, rd_stb, wr_stb);

  port_block_decoder #(.AW(AW), .PORTS(BLK_PORTS), .BASE(BLK_BASE)) u_blk (
    .clk(clk), .rst(rst), .acc(qual.acc), .addr(addr), .sel_n(blk_sel_n)
  );

  group_decoder #(.AW(AW), .SPAN(GRP_SPAN), .BASE(GRP_BASE)) u_grp (
    .acc(qual.acc), .wide(wide32), .addr(addr), .sel_n(grp_sel_n)
  );

  lane_latch_bank #(.AW(AW), .DW(DW), .BASE(OUT_BASE)) u_out (
    .clk(clk), .rst(rst), .wr(qual.wr), .word_addr(addr[AW-1:WLSB]),
    .lane_en(lane_en), .wdata(wdata), .q(out_q)
  );

  in_port_gate #(.AW(AW), .DW(DW), .BASE(IN_BASE)) u_in (
    .rd(qual.rd), .word_addr(addr[AW-1:WLSB]), .in_data(in_data),
    .rdata(rdata), .oe(rdata_oe)
  );

  // R1: a memory cycle never disturbs the output latches
  assert_mem_no_write_R1: assert property (@(posedge clk) disable iff (rst)
    !io_cycle |=> $stable(out_q));
  // R1: a memory cycle never selects anything
  assert_mem_no_select_R1: assert property (@(posedge clk) disable iff (rst)
    !io_cycle |-> (blk_sel_n == '1) && grp_sel_n && !rdata_oe);
  // R7: the input port never drives together with another select
  assert_read_exclusive_R7: assert property (@(posedge clk) disable iff (rst)
    rdata_oe |-> (blk_sel_n == '1) && grp_sel_n);
  // R8: without an I/O read the bus stays undriven and zero
  assert_idle_bus_R8: assert property (@(posedge clk) disable iff (rst)
    !(io_cycle && rd_stb) |-> !rdata_oe && (rdata == '0));
  // R9: the group select only appears on an aligned address
  assert_grp_aligned_R9: assert property (@(posedge clk) disable iff (rst)
    !grp_sel_n |-> (addr[$clog2(GRP_SPAN)-1:0] == '0) && wide32);
endmodule

// File: tb/test_io_port_decoder.sv
module test_io_port_decoder;
  logic        clk = 1'b0;
  logic        rst;
  logic        io_cycle, rd_stb, wr_stb, wide32;
  logic [1:0]  lane_en;
  logic [15:0] addr, wdata, in_data;
  logic [7:0]  blk_sel_n;
  logic        grp_sel_n;
  logic [15:0] out_q, rdata;
  logic        rdata_oe;

  int          checks = 0;
  int          fails  = 0;
  logic [15:0] m_q;

  always #4 clk = ~clk;

  io_port_decoder i_io_port_decoder (
    .clk(clk), .rst(rst), .io_cycle(io_cycle), .rd_stb(rd_stb), .wr_stb(wr_stb),
    .wide32(wide32), .lane_en(lane_en), .addr(addr), .wdata(wdata), .in_data(in_data),
    .blk_sel_n(blk_sel_n), .grp_sel_n(grp_sel_n), .out_q(out_q), .rdata(rdata),
    .rdata_oe(rdata_oe)
  );

  task automatic chk(input string req, input string ctx, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s (%s) actual=%h expected=%h", req, ctx, act, exp);
    end
  endtask

  function automatic logic [7:0] exp_blk(input logic io, rd, wr, input logic [15:0] a);
    if (io && (rd || wr) && a[15:3] == 13'h1DFF) return ~(8'h01 << a[2:0]);
    return 8'hFF;
  endfunction

  function automatic logic exp_oe(input logic io, rd, input logic [15:0] a);
    return io && rd && (a[15:1] == 15'h0032);
  endfunction

  function automatic logic exp_grp_n(input logic io, rd, wr, wide, input logic [15:0] a);
    return !(io && (rd || wr) && wide && a == 16'h0070);
  endfunction

  task automatic apply(input string ctx, input logic i_io, i_rd, i_wr, i_wide,
                       input logic [1:0] i_ln, input logic [15:0] i_a, i_wd, i_in);
    logic w_hit;
    io_cycle = i_io; rd_stb = i_rd; wr_stb = i_wr; wide32 = i_wide;
    lane_en = i_ln; addr = i_a; wdata = i_wd; in_data = i_in;
    #1;
    chk("R3", ctx, {24'h0, blk_sel_n}, {24'h0, exp_blk(i_io, i_rd, i_wr, i_a)});
    chk("R9", ctx, {31'h0, grp_sel_n}, {31'h0, exp_grp_n(i_io, i_rd, i_wr, i_wide, i_a)});
    if (exp_oe(i_io, i_rd, i_a)) begin
      chk("R7", ctx, {15'h0, rdata_oe, rdata}, {15'h0, 1'b1, i_in});
    end else begin
      chk("R8", ctx, {15'h0, rdata_oe, rdata}, 32'h0);
    end
    w_hit = i_io && i_wr && (i_a[15:1] == 15'h0020);
    @(posedge clk);
    if (rst) m_q = 16'h0;
    else if (w_hit) begin
      if (i_ln[0]) m_q[7:0]  = i_wd[7:0];
      if (i_ln[1]) m_q[15:8] = i_wd[15:8];
    end
    #1;
    if (rst)        chk("R10", ctx, {16'h0, out_q}, {16'h0, m_q});
    else if (w_hit) chk("R5", ctx, {16'h0, out_q}, {16'h0, m_q});
    else if (!i_io) chk("R1", ctx, {16'h0, out_q}, {16'h0, m_q});
    else            chk("R6", ctx, {16'h0, out_q}, {16'h0, m_q});
  endtask

  initial begin
    #(200000 * 8);
    fails++;
    $display("FAIL watchdog: run did not complete, actual=hung expected=done");
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd2024));
    rst = 1'b1; io_cycle = 0; rd_stb = 0; wr_stb = 0; wide32 = 0;
    lane_en = 0; addr = 0; wdata = 0; in_data = 0; m_q = 16'h0;
    @(posedge clk); @(posedge clk); #1;
    chk("R10", "reset state", {16'h0, out_q}, 32'h0);
    rst = 1'b0;

    // directed corner cases
    apply("R5 word write both lanes",   1, 0, 1, 0, 2'b11, 16'h0040, 16'hA55A, 16'h0);
    apply("R5 byte write 41h high only", 1, 0, 1, 0, 2'b10, 16'h0041, 16'h3C99, 16'h0);
    apply("R4 byte write 40h low only",  1, 0, 1, 0, 2'b01, 16'h0040, 16'hEE77, 16'h0);
    apply("R1 memory write to 40h",      0, 0, 1, 1, 2'b11, 16'h0040, 16'hFFFF, 16'h1234);
    apply("R1 memory read of 64h",       0, 1, 0, 0, 2'b11, 16'h0064, 16'h0, 16'hBEEF);
    apply("R2 alias write 1040h",        1, 0, 1, 0, 2'b11, 16'h1040, 16'h1111, 16'h0);
    apply("R2 alias read 0164h",         1, 1, 0, 0, 2'b11, 16'h0164, 16'h0, 16'h5555);
    apply("R7 read 65h no lanes",        1, 1, 0, 0, 2'b00, 16'h0065, 16'h0, 16'hC0DE);
    apply("R8 write to 64h",             1, 0, 1, 0, 2'b11, 16'h0064, 16'h2222, 16'hC0DE);
    apply("R6 read of latch port",       1, 1, 0, 0, 2'b11, 16'h0040, 16'h0, 16'h0);
    apply("R3 first block port",         1, 1, 0, 0, 2'b01, 16'hEFF8, 16'h0, 16'h0);
    apply("R3 last block port",          1, 0, 1, 0, 2'b10, 16'hEFFF, 16'h0, 16'h0);
    apply("R3 just below block",         1, 1, 0, 0, 2'b01, 16'hEFF7, 16'h0, 16'h0);
    apply("R3 no strobe",                1, 0, 0, 0, 2'b11, 16'hEFFA, 16'h0, 16'h0);
    apply("R9 aligned group",            1, 1, 0, 1, 2'b11, 16'h0070, 16'h0, 16'h0);
    apply("R9 misaligned group",         1, 1, 0, 1, 2'b11, 16'h0071, 16'h0, 16'h0);
    apply("R9 group without wide",       1, 0, 1, 0, 2'b11, 16'h0070, 16'h0, 16'h0);
    rst = 1'b1;
    apply("R10 reset beats write",       1, 0, 1, 0, 2'b11, 16'h0040, 16'h9999, 16'h0);
    rst = 1'b0;

    // constrained random mix
    for (int n = 0; n < 3000; n++) begin
      logic [15:0] a;
      logic        r, w;
      int          op;
      case ($urandom % 6)
        0:       a = 16'($urandom);
        1:       a = {13'h1DFF, 3'($urandom)};
        2:       a = {15'h0020, 1'($urandom)};
        3:       a = {15'h0032, 1'($urandom)};
        4:       a = {14'h001C, 2'($urandom)};
        default: a = {8'($urandom % 3), 8'h40 | 8'($urandom % 64)};
      endcase
      op = $urandom % 3;
      r  = (op == 0);
      w  = (op == 1);
      rst = ($urandom % 250 == 0);
      apply("random", ($urandom % 4) != 0, r, w, 1'($urandom), 2'($urandom),
            a, 16'($urandom), 16'($urandom));
    end
    rst = 1'b0;

    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule